// File: doc/BRIEF.md
# Privileged Configuration Register Access Controller

This block holds one 64-bit virtualization control register and rules on every read or write request made to it. For each request it looks at the requester's privilege level (0 to 3), the two nested-virtualization control bits, whether level 2 is enabled, whether level 3 exists and has granted access, and the debug-halt and secure-debug-disable flags. From these it picks exactly one outcome: direct register access, a redirect to a memory slot, a trap to level 2, a trap to level 3, or undefined. A trap carries a syndrome class code. The decision is combinational and is valid in the same cycle as the request strobe.

A write changes the register only when the outcome is direct access. The register also drives effective values for three fields that other logic consumes. The stack-enable field can be forced to 1 or to 0 by the current virtualization state. The two virtual-interrupt superpriority fields take effect only while the matching virtual interrupt is pending. The memory transfer behind a redirect and the entry into an exception are handled elsewhere. This block only reports the slot offset and passes slot read data through.

Top module: `hvcfg_access_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register bit is 0, and a direct read returns all zeros.
- R2: A request from level 0 always gives outcome undefined.
- R3: At level 1 with level 2 enabled and both nested bits (nv, nv2) at 1, the outcome is redirect. slot_offset is 0x0A0, and a read returns slot_rd_data unchanged.
- R4: At level 1 with level 2 enabled, nv=1 and nv2=0, the outcome is trap to level 2 with class 0x18. Every other level 1 case is undefined, including nv2=1 with nv=0.
- R5: At level 2, when level 3 is present and its enable is 0, the outcome is trap to level 3 with class 0x18. If halted and sec_dbg_dis are both 1 in that case, the outcome is undefined instead.
- R6: Requests at level 3, and level 2 requests not caught by R5, give direct access. A direct read returns the register.
- R7: Bits 63..23 and 13..12 always read as 0, and writes to them are ignored. Bits 22..14 and 11..0 are writable.
- R8: A write commits at the next clock edge only when its outcome is direct access. For any other outcome the register keeps its value. rd_data carries data only for reads whose outcome is direct or redirect, and is 0 otherwise.
- R9: eff_stack_en is 1 when level 2 is disabled, or when e2h and tge are both 1. Otherwise it is 0 when level 3 is present with its enable at 0. In all other cases it equals register bit 22.
- R10: eff_virq_super equals bit 7 AND virq_pend. eff_vfiq_super equals bit 8 AND vfiq_pend.
- R11: Outcome codes are: idle=0, direct=1, redirect=2, trap-to-2=3, trap-to-3=4, undefined=5. With no request the outcome is idle. syn_class is 0x18 for the two trap outcomes and 0 for all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| cur_level | input | 2 | Requester privilege level |
| lvl2_enabled | input | 1 | Level 2 enabled in current state |
| lvl3_present | input | 1 | Level 3 exists |
| hx_enable | input | 1 | Level 3 grant for this register |
| nv_bit | input | 1 | Nested-virtualization trap bit |
| nv2_bit | input | 1 | Nested-virtualization redirect bit |
| e2h_bit | input | 1 | Host-mode bit |
| tge_bit | input | 1 | Trap-general bit |
| halted | input | 1 | Core in debug halt |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| wr_data | input | 64 | Write data |
| slot_rd_data | input | 64 | Data read from the redirect slot |
| virq_pend | input | 1 | Virtual IRQ pending |
| vfiq_pend | input | 1 | Virtual FIQ pending |
| outcome | output | 3 | Access outcome code |
| syn_class | output | 6 | Trap syndrome class |
| rd_data | output | 64 | Read data |
| slot_offset | output | 12 | Redirect slot offset |
| eff_stack_en | output | 1 | Effective stack enable |
| eff_virq_super | output | 1 | Effective virtual IRQ superpriority |
| eff_vfiq_super | output | 1 | Effective virtual FIQ superpriority |

## Verification
Two things can happen in the same cycle: a direct write that is about to commit, and the effective-field outputs derived from the same register. The effective outputs must still show the old register contents until the clock edge. Only the next cycle may show the new contents, even when the override inputs change at that same moment. The bench provokes this with random direct writes while it flips the level-2, host-mode and pending inputs every cycle. Its model checks all outputs against the pre-commit register value and only then applies the write.

// File: rtl/hvcfg_pkg.sv
// Package: shared outcome encoding, field positions and the writable mask
// for the virtualization control register.
package hvcfg_pkg;
    localparam int CFG_W      = 64;
    localparam int SYN_W      = 6;
    localparam int BIT_STACK  = 22;
    localparam int BIT_VFIQ   = 8;
    localparam int BIT_VIRQ   = 7;
    localparam int HI_LO_BIT  = 14;
    localparam int LO_HI_BIT  = 11;

    localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_DIRECT   = 3'd1,
        ACC_REDIRECT = 3'd2,
        ACC_TRAP_L2  = 3'd3,
        ACC_TRAP_L3  = 3'd4,
        ACC_UNDEF    = 3'd5
    } acc_outcome_e;

    // Build the writable-bit mask from the two implemented field ranges.
    function automatic logic [CFG_W-1:0] impl_mask();
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < CFG_W; i++) begin
            if ((i >= HI_LO_BIT && i <= BIT_STACK) || (i <= LO_HI_BIT))
                m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/hvcfg_decide.sv
// Module: hvcfg_decide
// Purely combinational priority tree choosing the outcome of one access.
// Assumes all inputs are stable while req_valid is high.
module hvcfg_decide
    import hvcfg_pkg::*;
#(
    parameter int SYN_WIDTH = SYN_W
) (
    input  logic                 req_valid,
    input  logic [1:0]           cur_level,
    input  logic                 lvl2_enabled,
    input  logic                 lvl3_present,
    input  logic                 hx_enable,
    input  logic                 nv_bit,
    input  logic                 nv2_bit,
    input  logic                 halted,
    input  logic                 sec_dbg_dis,
    output acc_outcome_e         outcome,
    output logic [SYN_WIDTH-1:0] syn_class
);
    localparam logic [SYN_WIDTH-1:0] TRAP_CLASS = SYN_WIDTH'(SYN_SYSREG);

    logic l3_blocks;
    logic dbg_lock;

    assign l3_blocks = lvl3_present && !hx_enable;
    assign dbg_lock  = halted && sec_dbg_dis;

    // Prioritized decision per privilege level.
    always_comb begin
        outcome = ACC_IDLE;
        if (req_valid) begin
            unique case (cur_level)
                2'd0: outcome = ACC_UNDEF;
                2'd1: begin
                    if (lvl2_enabled && nv_bit && nv2_bit)
                        outcome = ACC_REDIRECT;
                    else if (lvl2_enabled && nv_bit)
                        outcome = ACC_TRAP_L2;
                    else
                        outcome = ACC_UNDEF;
                end
                2'd2: begin
                    if (l3_blocks)
                        outcome = dbg_lock ? ACC_UNDEF : ACC_TRAP_L3;
                    else
                        outcome = ACC_DIRECT;
                end
                default: outcome = ACC_DIRECT;
            endcase
        end
    end

    // Syndrome class accompanies only the two trap outcomes.
    always_comb begin
        syn_class = '0;
        if (outcome == ACC_TRAP_L2 || outcome == ACC_TRAP_L3)
            syn_class = TRAP_CLASS;
    end
endmodule

// File: rtl/hvcfg_store.sv
// Module: hvcfg_store
// Register storage. Only bits set in WR_MASK are writable; the others stay 0.
// Assumes wr_en is already qualified by the access decision.
module hvcfg_store #(
    parameter int               WIDTH   = 64,
    parameter logic [WIDTH-1:0] WR_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    // Synchronous clear, masked update on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_data & WR_MASK;
    end
endmodule

// File: rtl/hvcfg_effective.sv
// Module: hvcfg_effective
// Derives effective field values from stored bits and the virtualization state.
// Assumes the stored bits come straight from the register.
module hvcfg_effective (
    input  logic stack_bit,
    input  logic vfiq_bit,
    input  logic virq_bit,
    input  logic lvl2_enabled,
    input  logic lvl3_present,
    input  logic hx_enable,
    input  logic e2h_bit,
    input  logic tge_bit,
    input  logic virq_pend,
    input  logic vfiq_pend,
    output logic eff_stack_en,
    output logic eff_virq_super,
    output logic eff_vfiq_super
);
    logic host_mode;
    assign host_mode = e2h_bit && tge_bit;

    // Force-to-1 wins over force-to-0, else the stored bit.
    always_comb begin
        if (!lvl2_enabled || host_mode)
            eff_stack_en = 1'b1;
        else if (lvl3_present && !hx_enable)
            eff_stack_en = 1'b0;
        else
            eff_stack_en = stack_bit;
    end

    // Superpriority matters only while the matching interrupt is pending.
    always_comb begin
        eff_virq_super = virq_bit && virq_pend;
        eff_vfiq_super = vfiq_bit && vfiq_pend;
    end
endmodule

// File: rtl/hvcfg_access_ctrl.sv
// Module: hvcfg_access_ctrl (top)
// Holds the control register, decides each access outcome in the request
// cycle, commits direct writes on the next edge and drives effective fields.
// Assumes request inputs are held stable for the whole request cycle.
module hvcfg_access_ctrl
    import hvcfg_pkg::*;
#(
    parameter int                  DATA_W   = CFG_W,
    parameter int                  CLASS_W  = SYN_W,
    parameter int                  SLOT_W   = 12,
    parameter logic [SLOT_W-1:0]   SLOT_OFS = 12'h0A0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         cur_level,
    input  logic               lvl2_enabled,
    input  logic               lvl3_present,
    input  logic               hx_enable,
    input  logic               nv_bit,
    input  logic               nv2_bit,
    input  logic               e2h_bit,
    input  logic               tge_bit,
    input  logic               halted,
    input  logic               sec_dbg_dis,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  slot_rd_data,
    input  logic               virq_pend,
    input  logic               vfiq_pend,
    output logic [2:0]         outcome,
    output logic [CLASS_W-1:0] syn_class,
    output logic [DATA_W-1:0]  rd_data,
    output logic [SLOT_W-1:0]  slot_offset,
    output logic               eff_stack_en,
    output logic               eff_virq_super,
    output logic               eff_vfiq_super
);
    localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(impl_mask());

    acc_outcome_e      dec_out;
    logic [DATA_W-1:0] cfg_q;
    logic              commit;

    hvcfg_decide #(.SYN_WIDTH(CLASS_W)) u_decide (
        .req_valid    (req_valid),
        .cur_level    (cur_level),
        .lvl2_enabled (lvl2_enabled),
        .lvl3_present (lvl3_present),
        .hx_enable    (hx_enable),
        .nv_bit       (nv_bit),
        .nv2_bit      (nv2_bit),
        .halted       (halted),
        .sec_dbg_dis  (sec_dbg_dis),
        .outcome      (dec_out),
        .syn_class    (syn_class)
    );

    assign outcome = dec_out;
    assign commit  = req_valid && req_write && (dec_out == ACC_DIRECT);

    hvcfg_store #(.WIDTH(DATA_W), .WR_MASK(WR_MASK)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_data (wr_data),
        .q       (cfg_q)
    );

    hvcfg_effective u_eff (
        .stack_bit      (cfg_q[BIT_STACK]),
        .vfiq_bit       (cfg_q[BIT_VFIQ]),
        .virq_bit       (cfg_q[BIT_VIRQ]),
        .lvl2_enabled   (lvl2_enabled),
        .lvl3_present   (lvl3_present),
        .hx_enable      (hx_enable),
        .e2h_bit        (e2h_bit),
        .tge_bit        (tge_bit),
        .virq_pend      (virq_pend),
        .vfiq_pend      (vfiq_pend),
        .eff_stack_en   (eff_stack_en),
        .eff_virq_super (eff_virq_super),
        .eff_vfiq_super (eff_vfiq_super)
    );

    assign slot_offset = SLOT_OFS;

    // Read data only for reads that reach the register or the slot.
    always_comb begin
        rd_data = '0;
        if (req_valid && !req_write) begin
            if (dec_out == ACC_DIRECT)
                rd_data = cfg_q;
            else if (dec_out == ACC_REDIRECT)
                rd_data = slot_rd_data;
        end
    end
endmodule

// File: rtl/hvcfg_access_chk.sv
// Module: hvcfg_access_chk
// Property checker bound to hvcfg_access_ctrl; observes ports and stored state.
module hvcfg_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  cur_level,
    input logic        lvl2_enabled,
    input logic        lvl3_present,
    input logic        hx_enable,
    input logic        nv_bit,
    input logic        nv2_bit,
    input logic        halted,
    input logic        sec_dbg_dis,
    input logic        virq_pend,
    input logic        vfiq_pend,
    input logic [2:0]  outcome,
    input logic [5:0]  syn_class,
    input logic [63:0] rd_data,
    input logic [63:0] cfg_q,
    input logic        eff_stack_en,
    input logic        eff_virq_super,
    input logic        eff_vfiq_super
);
    AST_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_level == 2'd0 |-> outcome == 3'd5); // R2
    AST_REDIRECT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        outcome == 3'd2 |-> req_valid && cur_level == 2'd1 && nv_bit && nv2_bit && lvl2_enabled); // R3
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 3'd3 || outcome == 3'd4) |-> syn_class == 6'h18); // R4
    AST_HALT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_level == 2'd2 && lvl3_present && !hx_enable && halted && sec_dbg_dis
        |-> outcome == 3'd5); // R5
    AST_L3_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_level == 2'd3 |-> outcome == 3'd1); // R6
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        outcome == 3'd1 && !req_write |-> rd_data[63:23] == '0 && rd_data[13:12] == 2'b00); // R7
    AST_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && outcome != 3'd1 |=> $stable(cfg_q)); // R8
    AST_STACK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl2_enabled |-> eff_stack_en); // R9
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !virq_pend |-> !eff_virq_super); // R10
    AST_FIQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !vfiq_pend |-> !eff_vfiq_super); // R10
    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> outcome == 3'd0 && syn_class == '0 && rd_data == '0); // R11
endmodule

bind hvcfg_access_ctrl hvcfg_access_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .cur_level      (cur_level),
    .lvl2_enabled   (lvl2_enabled),
    .lvl3_present   (lvl3_present),
    .hx_enable      (hx_enable),
    .nv_bit         (nv_bit),
    .nv2_bit        (nv2_bit),
    .halted         (halted),
    .sec_dbg_dis    (sec_dbg_dis),
    .virq_pend      (virq_pend),
    .vfiq_pend      (vfiq_pend),
    .outcome        (outcome),
    .syn_class      (syn_class),
    .rd_data        (rd_data),
    .cfg_q          (cfg_q),
    .eff_stack_en   (eff_stack_en),
    .eff_virq_super (eff_virq_super),
    .eff_vfiq_super (eff_vfiq_super)
);

// File: tb/sim_hvcfg_access_ctrl.sv
// Bench: behavioural reference model compared on every falling edge.
module sim_hvcfg_access_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, req_valid, req_write, lvl2_enabled, lvl3_present, hx_enable;
    logic        nv_bit, nv2_bit, e2h_bit, tge_bit, halted, sec_dbg_dis, virq_pend, vfiq_pend;
    logic [1:0]  cur_level;
    logic [63:0] wr_data, slot_rd_data, rd_data;
    logic [2:0]  outcome;
    logic [5:0]  syn_class;
    logic [11:0] slot_offset;
    logic        eff_stack_en, eff_virq_super, eff_vfiq_super;

    hvcfg_access_ctrl u0 (.*);

    localparam logic [63:0] WMASK = {41'b0, 9'h1FF, 2'b00, 12'hFFF};
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] mdl_q = '0;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_outcome();
        if (!req_valid) return 0;
        if (cur_level == 0) return 5;
        if (cur_level == 1) begin
            if (lvl2_enabled && nv_bit && nv2_bit) return 2;
            if (lvl2_enabled && nv_bit && !nv2_bit) return 3;
            return 5;
        end
        if (cur_level == 2 && lvl3_present && !hx_enable)
            return (halted && sec_dbg_dis) ? 5 : 4;
        return 1;
    endfunction

    function automatic string ref_tag();
        if (!req_valid) return "R11";
        case (cur_level)
            2'd0: return "R2";
            2'd1: return (lvl2_enabled && nv_bit && nv2_bit) ? "R3" : "R4";
            2'd2: return (lvl3_present && !hx_enable) ? "R5" : "R6";
            default: return "R6";
        endcase
    endfunction

    // Compare every output against the model, then apply a pending commit.
    always @(negedge clk) begin
        if (!rst_n) begin
            mdl_q = '0;
        end else begin
            int          eo;
            logic [63:0] erd;
            logic        estk;
            eo  = ref_outcome();
            erd = '0;
            if (req_valid && !req_write && eo == 1) erd = mdl_q;
            if (req_valid && !req_write && eo == 2) erd = slot_rd_data;
            check(ref_tag(), "outcome", 64'(outcome), 64'(eo));
            check("R11", "class", 64'(syn_class), (eo == 3 || eo == 4) ? 64'h18 : 64'h0);
            check("R8", "rd_data", rd_data, erd);
            if (eo == 2) check("R3", "slot_offset", 64'(slot_offset), 64'h0A0);
            if (!lvl2_enabled || (e2h_bit && tge_bit)) estk = 1'b1;
            else if (lvl3_present && !hx_enable) estk = 1'b0;
            else estk = mdl_q[22];
            check("R9", "eff_stack_en", 64'(eff_stack_en), 64'(estk));
            check("R10", "eff_virq_super", 64'(eff_virq_super), 64'(mdl_q[7] & virq_pend));
            check("R10", "eff_vfiq_super", 64'(eff_vfiq_super), 64'(mdl_q[8] & vfiq_pend));
            if (req_valid && req_write && eo == 1) mdl_q = wr_data & WMASK;
        end
    end

    task automatic drive(bit v, bit w, bit [1:0] lv, bit l2, bit l3, bit hx, bit nv, bit nv2,
                         bit e2h, bit tge, bit hal, bit sdd, logic [63:0] wd, logic [63:0] sd,
                         bit vi, bit vf);
        @(posedge clk); #2;
        req_valid = v; req_write = w; cur_level = lv; lvl2_enabled = l2; lvl3_present = l3;
        hx_enable = hx; nv_bit = nv; nv2_bit = nv2; e2h_bit = e2h; tge_bit = tge;
        halted = hal; sec_dbg_dis = sdd; wr_data = wd; slot_rd_data = sd;
        virq_pend = vi; vfiq_pend = vf;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(0,0,0,0,0,0,0,0,0,0,0,0,'0,'0,0,0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset value read directly at level 3
        drive(1,0,3,1,1,1,0,0,0,0,0,0,'0,'0,0,0);
        @(negedge clk) check("R1", "reset read", rd_data, 64'h0);
        // R7: write all ones, reserved bits stay zero
        drive(1,1,3,1,1,1,0,0,0,0,0,0,'1,'0,0,0);
        drive(1,0,3,1,1,1,0,0,0,0,0,0,'0,'0,0,0);
        @(negedge clk) check("R7", "masked readback", rd_data, WMASK);
        // R8: trapped write at level 1 must not commit
        drive(1,1,1,1,1,1,1,0,0,0,0,0,'0,'0,0,0);
        @(negedge clk) check("R4", "trap l2", 64'(outcome), 64'd3);
        drive(1,0,2,1,1,1,0,0,0,0,0,0,'0,'0,0,0);
        @(negedge clk) check("R8", "unchanged after trap", rd_data, WMASK);
        // R5: halted with secure debug disabled
        drive(1,0,2,1,1,0,0,0,0,0,1,1,'0,'0,0,0);
        @(negedge clk) check("R5", "halt undefined", 64'(outcome), 64'd5);
        drive(1,0,2,1,1,0,0,0,0,0,1,0,'0,'0,0,0);
        @(negedge clk) check("R5", "trap l3", 64'(outcome), 64'd4);
        // R9: forced zero despite stored one
        drive(0,0,0,1,1,0,0,0,0,0,0,0,'0,'0,0,0);
        @(negedge clk) check("R9", "forced zero", 64'(eff_stack_en), 64'd0);
        // R10: pending gates superpriority
        drive(0,0,0,1,1,1,0,0,0,0,0,0,'0,'0,1,0);
        @(negedge clk) check("R10", "virq gated", 64'(eff_virq_super), 64'd1);
        // R3: redirect read returns slot data
        drive(1,0,1,1,1,1,1,1,0,0,0,0,'0,64'hDEAD_BEEF_0123_4567,0,0);
        @(negedge clk) check("R3", "slot data", rd_data, 64'hDEAD_BEEF_0123_4567);
        // Random traffic across all inputs
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            drive(r[0] | r[1], r[2], r[4:3], r[5] | r[6], r[7], r[8] | r[9], r[10], r[11],
                  r[12], r[13], r[14], r[15], {$urandom(), $urandom()},
                  {$urandom(), $urandom()}, r[16], r[17]);
        end
        @(negedge clk);
        summary();
        $finish;
    end
endmodule